// File: doc/BRIEF.md
# Memory Self-Test Engine

This block is an on-chip test engine for a small synchronous single-port RAM with one cycle of read latency. A single start pulse makes it take over the RAM control lines. It writes and reads back four data backgrounds: solid zeros, solid ones, a checkerboard whose word depends on address parity, and the inverse checkerboard. Each write pass covers the whole array before the matching read pass begins. Two interleaved passes follow, one rising and one falling through the addresses. At each address they read the word and then write its complement, which exposes cells that are disturbed when a neighbour is written.

The engine makes all stimulus and expected data itself and compares the read data on chip. The only results are a done flag, a sticky fail flag and the address of the first mismatch. The engine keeps running after a mismatch, so a run always takes the same number of cycles. Done stays high until the next start pulse.

Top module: `mbist_engine`

## Requirements
- R1: After reset, done, fail, ramWe and ramRe are all low.
- R2: A run issues exactly one RAM operation per cycle and never asserts ramWe and ramRe together. It issues 6*DEPTH reads and 6*DEPTH writes, in this element order: write zeros, read zeros, write ones, read ones, write checkerboard, read checkerboard, write inverse, read inverse, rising interleaved pass, falling interleaved pass. The first eight elements all run in rising address order.
- R3: The checkerboard word sets the even-numbered data bits at even addresses (0x55 for 8 bits) and is the complement at odd addresses. The inverse checkerboard is its complement. After a fault-free run every RAM word holds the inverse checkerboard.
- R4: A data bit stuck at 0 or at 1 in any word, including address 0 and the top address, makes fail high at done, with failAddr equal to that word's address.
- R5: Read data is compared in the cycle after the read is driven. If a failing read is driven in cycle c, fail is high from cycle c+2. For a stuck-at-1 bit at address 5 with DEPTH 16, this means fail first reads high 23 cycles after the start edge.
- R6: failAddr holds the address of the first mismatch of a run. Later mismatches at other addresses do not change it.
- R7: done rises exactly 12*DEPTH cycles after the clock edge that accepts start. It then stays high, with no RAM operation, until the next start.
- R8: A start pulse while a run is in progress is ignored. The run's length and result are unchanged.
- R9: An accepted start clears done and fail at the accepting edge.
- R10: A coupling fault, in which a write to one word inverts a bit of the next-higher word, is reported at the victim address.
- R11: In each interleaved pass, every read is followed in the next cycle by a write to the same address. The rising pass reads the inverse checkerboard and writes the checkerboard. The falling pass reads the checkerboard and writes the inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a run when no run is active |
| ramAddr | output | ADDR_W | RAM address |
| ramWdata | output | DATA_W | RAM write data |
| ramWe | output | 1 | RAM write enable |
| ramRe | output | 1 | RAM read enable |
| ramRdata | input | DATA_W | RAM read data, valid one cycle after ramRe |
| done | output | 1 | Run complete, held until next start |
| fail | output | 1 | At least one mismatch seen in this run |
| failAddr | output | ADDR_W | Address of the first mismatch |

## Verification
A corrupted element counter or address step shows at the ports at once: the op counts no longer match, or a read finds data that an element never wrote. Either way fail is raised within two cycles, and the done edge moves away from 12*DEPTH. A wrong background word or inverse polarity also trips fail on a fault-free RAM, and it leaves the final RAM image different from the inverse checkerboard. A wrong compare alignment shows on the first read, either as a false fail or as a fail cycle other than c+2 for an injected stuck bit.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

  typedef enum logic [1:0] {
    PAT_ZERO,
    PAT_ONE,
    PAT_CHK,
    PAT_ICHK
  } patSel_e;

  typedef enum logic [3:0] {
    EL_W0,
    EL_R0,
    EL_W1,
    EL_R1,
    EL_WC,
    EL_RC,
    EL_WI,
    EL_RI,
    EL_UP,
    EL_DN
  } elem_e;

  typedef struct packed {
    logic    clr;
    logic    rdEn;
    logic    wrEn;
    patSel_e rdPat;
    patSel_e wrPat;
  } ctlStrobe_t;

endpackage

// File: rtl/mbist_ctrl.sv
module mbist_ctrl
  import mbist_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output ctlStrobe_t        strobe,
  output logic [ADDR_W-1:0] addr,
  output logic              done
);

  localparam logic [ADDR_W-1:0] MAX_A = '1;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} state_e;

  state_e  state;
  elem_e   elem;
  elem_e   nextElem;
  logic    second;
  logic    isRd, isWr, isRw, descend;
  patSel_e rdPat, wrPat;
  logic    running, stepEnd, lastAddr, lastElem, finishing, accept;

  always_comb begin
    isRd    = 1'b0;
    isWr    = 1'b0;
    isRw    = 1'b0;
    descend = 1'b0;
    rdPat   = PAT_ZERO;
    wrPat   = PAT_ZERO;
    case (elem)
      EL_W0: begin isWr = 1'b1; wrPat = PAT_ZERO; end
      EL_R0: begin isRd = 1'b1; rdPat = PAT_ZERO; end
      EL_W1: begin isWr = 1'b1; wrPat = PAT_ONE;  end
      EL_R1: begin isRd = 1'b1; rdPat = PAT_ONE;  end
      EL_WC: begin isWr = 1'b1; wrPat = PAT_CHK;  end
      EL_RC: begin isRd = 1'b1; rdPat = PAT_CHK;  end
      EL_WI: begin isWr = 1'b1; wrPat = PAT_ICHK; end
      EL_RI: begin isRd = 1'b1; rdPat = PAT_ICHK; end
      EL_UP: begin isRw = 1'b1; rdPat = PAT_ICHK; wrPat = PAT_CHK; end
      EL_DN: begin isRw = 1'b1; descend = 1'b1; rdPat = PAT_CHK; wrPat = PAT_ICHK; end
      default: ;
    endcase
  end

  assign running   = (state == ST_RUN);
  assign stepEnd   = isRw ? second : 1'b1;
  assign lastAddr  = descend ? (addr == '0) : (addr == MAX_A);
  assign lastElem  = (elem == EL_DN);
  assign finishing = running && stepEnd && lastAddr && lastElem;
  assign accept    = start && !running;
  assign nextElem  = elem_e'(elem + 4'd1);

  always_comb begin
    strobe.clr   = accept;
    strobe.rdEn  = running && (isRd || (isRw && !second));
    strobe.wrEn  = running && (isWr || (isRw && second));
    strobe.rdPat = rdPat;
    strobe.wrPat = wrPat;
  end

  assign done = (state == ST_DONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      elem   <= EL_W0;
      addr   <= '0;
      second <= 1'b0;
    end else if (accept) begin
      state  <= ST_RUN;
      elem   <= EL_W0;
      addr   <= '0;
      second <= 1'b0;
    end else if (running) begin
      if (isRw) second <= !second;
      if (stepEnd) begin
        if (lastAddr) begin
          if (lastElem) begin
            state <= ST_DONE;
          end else begin
            elem <= nextElem;
            addr <= (nextElem == EL_DN) ? MAX_A : '0;
          end
        end else begin
          addr <= descend ? addr - 1'b1 : addr + 1'b1;
        end
      end
    end
  end

  a_r2_one_op: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.wrEn && strobe.rdEn));

  a_r7_done_hold: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> (done && !strobe.wrEn && !strobe.rdEn));

  a_r8_busy_ignore: assert property (@(posedge clk) disable iff (!rstN)
    (running && start && !finishing) |=> running);

  a_r11_rw_pair: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdEn && isRw) |=> (strobe.wrEn && $stable(addr)));

endmodule

// File: rtl/mbist_dp.sv
module mbist_dp
  import mbist_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] wrData,
  output logic              fail,
  output logic [ADDR_W-1:0] failAddr
);

  logic [DATA_W-1:0] chkEven;
  logic [DATA_W-1:0] expWord;
  logic              cmpValid;
  logic [ADDR_W-1:0] cmpAddr;
  logic [DATA_W-1:0] cmpExp;
  logic              mismatch;

  for (genvar i = 0; i < DATA_W; i++) begin : g_chk
    assign chkEven[i] = ((i % 2) == 0);
  end

  function automatic logic [DATA_W-1:0] patWord(input patSel_e sel, input logic odd,
                                                input logic [DATA_W-1:0] cb);
    case (sel)
      PAT_ZERO: patWord = '0;
      PAT_ONE:  patWord = '1;
      PAT_CHK:  patWord = odd ? ~cb : cb;
      default:  patWord = odd ? cb : ~cb;
    endcase
  endfunction

  always_comb wrData  = patWord(strobe.wrPat, addr[0], chkEven);
  always_comb expWord = patWord(strobe.rdPat, addr[0], chkEven);

  assign mismatch = cmpValid && (rdData != cmpExp);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpValid <= 1'b0;
      cmpAddr  <= '0;
      cmpExp   <= '0;
      fail     <= 1'b0;
      failAddr <= '0;
    end else begin
      cmpValid <= strobe.rdEn;
      if (strobe.rdEn) begin
        cmpAddr <= addr;
        cmpExp  <= expWord;
      end
      if (strobe.clr) begin
        fail     <= 1'b0;
        failAddr <= '0;
      end else if (mismatch && !fail) begin
        fail     <= 1'b1;
        failAddr <= cmpAddr;
      end
    end
  end

  a_r6_first_addr: assert property (@(posedge clk) disable iff (!rstN)
    (fail && !strobe.clr) |=> (fail && $stable(failAddr)));

  a_r9_clear: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clr |=> !fail);

endmodule

// File: rtl/mbist_engine.sv
module mbist_engine
  import mbist_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramWdata,
  output logic              ramWe,
  output logic              ramRe,
  input  logic [DATA_W-1:0] ramRdata,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] failAddr
);

  ctlStrobe_t        strobe;
  logic [ADDR_W-1:0] addr;

  mbist_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobe (strobe),
    .addr   (addr),
    .done   (done)
  );

  mbist_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .addr     (addr),
    .rdData   (ramRdata),
    .wrData   (ramWdata),
    .fail     (fail),
    .failAddr (failAddr)
  );

  assign ramAddr = addr;
  assign ramWe   = strobe.wrEn;
  assign ramRe   = strobe.rdEn;

endmodule

// File: tb/mbist_engine_tb_top.sv
module mbist_engine_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int RUN_CYC = 12 * DEPTH;

  typedef struct packed {
    logic [2:0] kind;
    logic [3:0] fa;
    logic [2:0] fb;
    logic       expFail;
    logic [3:0] expAddr;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 4'd0,  3'd0, 1'b0, 4'd0},
    '{3'd2, 4'd5,  3'd3, 1'b1, 4'd5},
    '{3'd1, 4'd0,  3'd0, 1'b1, 4'd0},
    '{3'd1, 4'd15, 3'd7, 1'b1, 4'd15},
    '{3'd3, 4'd6,  3'd2, 1'b1, 4'd7},
    '{3'd3, 4'd14, 3'd0, 1'b1, 4'd15},
    '{3'd4, 4'd12, 3'd1, 1'b1, 4'd2}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] ramAddr;
  logic [DATA_W-1:0] ramWdata;
  logic              ramWe, ramRe;
  logic [DATA_W-1:0] ramRdata = '0;
  logic              done, fail;
  logic [ADDR_W-1:0] failAddr;

  int checks = 0;
  int errors = 0;
  int fKind = 0, fAddr = 0, fBit = 0;
  int nRd = 0, nWr = 0;
  int doneCyc = 0, failCyc = 0;

  logic [DATA_W-1:0] mem [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  mbist_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rstN(rstN), .start(start),
    .ramAddr(ramAddr), .ramWdata(ramWdata), .ramWe(ramWe), .ramRe(ramRe),
    .ramRdata(ramRdata), .done(done), .fail(fail), .failAddr(failAddr)
  );

  function automatic logic [DATA_W-1:0] faulty(input int a, input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] r = d;
    if (fKind == 1 && a == fAddr) r[fBit] = 1'b0;
    if (fKind == 2 && a == fAddr) r[fBit] = 1'b1;
    if (fKind == 4 && a == fAddr) r[fBit] = 1'b0;
    if (fKind == 4 && a == 2)     r[0] = 1'b1;
    return r;
  endfunction

  // behavioural RAM, one cycle read latency, with fault injection
  always @(posedge clk) begin
    if (ramWe) begin
      mem[ramAddr] <= faulty(int'(ramAddr), ramWdata);
      if (fKind == 3 && int'(ramAddr) == fAddr && fAddr < DEPTH - 1)
        mem[fAddr+1][fBit] <= ~mem[fAddr+1][fBit];
    end
    if (ramRe) ramRdata <= mem[ramAddr];
  end

  always @(posedge clk) begin
    if (ramRe) nRd++;
    if (ramWe) nWr++;
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic runTest(input int kind, input int fa, input int fb, input int midAt);
    fKind = kind; fAddr = fa; fBit = fb;
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    #1;
    start = 1'b0;
    nRd = 0; nWr = 0; doneCyc = 0; failCyc = 0;
    check(!done && !fail, "R9 start clears done/fail", int'({done, fail}), 0);
    for (int c = 1; c <= RUN_CYC + 20; c++) begin
      @(posedge clk);
      #1;
      start = (c == midAt);
      if (fail && failCyc == 0) failCyc = c;
      if (done) begin
        doneCyc = c;
        break;
      end
    end
    start = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(!done,  "R1 done low",  int'(done),  0);
    check(!fail,  "R1 fail low",  int'(fail),  0);
    check(!ramWe, "R1 ramWe low", int'(ramWe), 0);
    check(!ramRe, "R1 ramRe low", int'(ramRe), 0);
    @(negedge clk);
    rstN = 1'b1;

    // table of fault cases
    for (int v = 0; v < NVEC; v++) begin
      runTest(int'(VECS[v].kind), int'(VECS[v].fa), int'(VECS[v].fb), 0);
      check(doneCyc == RUN_CYC, "R7 done cycle", doneCyc, RUN_CYC);
      check(nRd == 6 * DEPTH, "R2 read count", nRd, 6 * DEPTH);
      check(nWr == 6 * DEPTH, "R2 write count", nWr, 6 * DEPTH);
      check(fail == VECS[v].expFail, "R4/R10 fail flag", int'(fail), int'(VECS[v].expFail));
      if (VECS[v].expFail)
        check(failAddr == VECS[v].expAddr, "R4/R6/R10 failAddr",
              int'(failAddr), int'(VECS[v].expAddr));
      if (VECS[v].kind == 0) begin
        // R3 and R11: final image is the inverse checkerboard
        for (int a = 0; a < DEPTH; a++)
          check(mem[a] == ((a % 2 == 1) ? 8'h55 : 8'hAA), "R3 R11 final image",
                int'(mem[a]), (a % 2 == 1) ? 'h55 : 'hAA);
      end
    end

    // R5 compare latency: stuck-at-1 at address 5
    runTest(2, 5, 3, 0);
    check(failCyc == DEPTH + 7, "R5 fail cycle", failCyc, DEPTH + 7);

    // R8 start while running is ignored
    runTest(0, 0, 0, 50);
    check(doneCyc == RUN_CYC, "R8 run length", doneCyc, RUN_CYC);
    check(!fail, "R8 result", int'(fail), 0);
    check(nRd == 6 * DEPTH, "R8 read count", nRd, 6 * DEPTH);

    // R6: a second fault at a later address does not move failAddr
    runTest(4, 9, 2, 0);
    check(failAddr == 4'd2, "R6 first address kept", int'(failAddr), 2);

    // R7 done holds with no RAM traffic
    for (int k = 0; k < 10; k++) begin
      @(posedge clk);
      #1;
      check(done && !ramWe && !ramRe, "R7 done hold", int'({done, ramWe, ramRe}), 4);
    end

    // R9: a new start clears a stale fail
    check(fail, "R9 fail set before restart", int'(fail), 1);
    runTest(0, 0, 0, 0);
    check(!fail && doneCyc == RUN_CYC, "R9 clean rerun", int'(fail), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule